// File: doc/BRIEF.md
# SDRAM Refresh Debt Scheduler

This controller-side block decides when the memory controller must send Auto Refresh commands. A free-running interval counter produces one tick per average refresh period. Each tick adds one refresh to an owed count, called the debt. While the debt is non-zero the block raises a refresh request to the command arbiter. The arbiter may delay that request while it serves traffic. When the owed count reaches its limit the request becomes urgent, and the arbiter must then serve it ahead of any other command. Each refresh the arbiter grants removes one unit of debt.

The block also sequences self-refresh. A self-refresh request is accepted only when no refresh is owed and the arbiter reports every bank idle. On acceptance the block asks for an Auto Refresh command in the same cycle that it pulls the clock-enable output low. On exit it raises clock enable and holds a NOP-only window for a fixed number of cycles. After that window, normal refresh tracking restarts from a fresh interval.

Top module: `rfsh_sched`

## Requirements
- R1: After reset, debt_o is 0, ref_req_o, ref_urgent_o, sr_cmd_o, sr_active_o and nop_only_o are 0, and cke_o is 1.
- R2: In normal operation debt_o rises by one every TICK_CYCLES clock cycles. The first rise comes TICK_CYCLES cycles after reset is released.
- R3: In normal operation ref_req_o is 1 exactly when debt_o is non-zero.
- R4: ref_urgent_o is 1 exactly when debt_o equals MAX_DEBT (8 by default).
- R5: debt_o never exceeds MAX_DEBT. A tick that arrives at MAX_DEBT with no grant leaves the debt at MAX_DEBT.
- R6: A cycle with ref_gnt_i high lowers debt_o by one when debt_o is non-zero. A grant while debt_o is 0 is ignored. A grant and a tick in the same cycle leave debt_o unchanged.
- R7: A self-refresh request on sr_req_i is accepted only when debt_o is 0 and bank_idle_i is 1. In the accepting cycle sr_cmd_o is 1 and cke_o is 0 in the same cycle.
- R8: While sr_active_o is 1, cke_o is 0, nop_only_o is 1, no refresh is requested, and debt_o stays 0.
- R9: The cycle after sr_exit_i is seen in self-refresh, cke_o is 1 and nop_only_o is 1. nop_only_o stays 1 for EXIT_WAIT cycles, then the block resumes normal operation with a fresh tick interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bank_idle_i | input | 1 | Arbiter reports all banks precharged |
| ref_gnt_i | input | 1 | Arbiter issues the requested Auto Refresh this cycle |
| sr_req_i | input | 1 | Request to enter self-refresh |
| sr_exit_i | input | 1 | Request to leave self-refresh (clock is stable) |
| ref_req_o | output | 1 | Refresh owed |
| ref_urgent_o | output | 1 | Postponement limit reached, refresh must go next |
| sr_cmd_o | output | 1 | Issue Auto Refresh as self-refresh entry |
| cke_o | output | 1 | Clock enable to the DRAM |
| nop_only_o | output | 1 | Only NOP/deselect may be issued |
| sr_active_o | output | 1 | DRAM is in self-refresh |
| debt_o | output | DW | Number of refreshes owed |

## Verification
The hardest case to reach is a tick and a grant landing in the same cycle. The same difficulty applies when a tick lands at the saturation limit. Both need the interval phase to be known exactly. The stimulus table therefore holds the grant input for whole, counted stretches of cycles, so that the tick phase is known at every vector boundary. It then places a single-cycle grant exactly on the tick cycle, and holds the grant input low through ticks at full debt. Self-refresh entry is blocked once by a busy bank and later by owed debt, to show both gates of the acceptance condition.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_SELF = 2'd1,
    ST_EXIT = 2'd2
  } sr_state_e;
endpackage

// File: rtl/rfsh_tick.sv
module rfsh_tick #(
  parameter int TICK_CYCLES = 780
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!run_i)      cnt_q <= '0;  // fresh interval after self-refresh
    else if (cnt_q == LAST) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rfsh_debt.sv
module rfsh_debt #(
  parameter int MAX_DEBT = 8,
  parameter int DW       = $clog2(MAX_DEBT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          gnt_i,
  output logic [DW-1:0] debt_o,
  output logic          zero_o,
  output logic          full_o
);
  localparam logic [DW-1:0] MAXV = DW'(MAX_DEBT);

  logic [DW-1:0] debt_q;
  logic up, dn;

  assign zero_o = (debt_q == '0);
  assign full_o = (debt_q == MAXV);
  assign dn     = gnt_i && !zero_o;
  // at the limit a tick is only absorbed when a grant pays one off
  assign up     = tick_i && (!full_o || dn);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) debt_q <= '0;
    else begin
      unique case ({up, dn})
        2'b10:   debt_q <= debt_q + 1'b1;
        2'b01:   debt_q <= debt_q - 1'b1;
        default: debt_q <= debt_q;
      endcase
    end
  end

  assign debt_o = debt_q;
endmodule

// File: rtl/rfsh_sr_fsm.sv
module rfsh_sr_fsm
  import rfsh_pkg::*;
#(
  parameter int EXIT_WAIT = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sr_req_i,
  input  logic sr_exit_i,
  input  logic debt_zero_i,
  input  logic bank_idle_i,
  output logic run_o,
  output logic enter_o,
  output logic cke_o,
  output logic nop_only_o,
  output logic sr_active_o
);
  localparam int WW = (EXIT_WAIT > 1) ? $clog2(EXIT_WAIT) : 1;
  localparam logic [WW-1:0] WLAST = WW'(EXIT_WAIT - 1);

  sr_state_e st_q, st_d;
  logic [WW-1:0] wcnt_q;

  assign enter_o     = (st_q == ST_RUN) && sr_req_i && debt_zero_i && bank_idle_i;
  assign run_o       = (st_q == ST_RUN);
  assign cke_o       = (run_o && !enter_o) || (st_q == ST_EXIT);
  assign nop_only_o  = (st_q != ST_RUN);
  assign sr_active_o = (st_q == ST_SELF);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RUN:  if (enter_o) st_d = ST_SELF;
      ST_SELF: if (sr_exit_i) st_d = ST_EXIT;
      ST_EXIT: if (wcnt_q == WLAST) st_d = ST_RUN;
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_RUN;
      wcnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_EXIT && wcnt_q != WLAST) wcnt_q <= wcnt_q + 1'b1;
      else                                    wcnt_q <= '0;
    end
  end
endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched #(
  parameter int TICK_CYCLES = 780,
  parameter int MAX_DEBT    = 8,
  parameter int EXIT_WAIT   = 200,
  parameter int DW          = $clog2(MAX_DEBT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bank_idle_i,
  input  logic          ref_gnt_i,
  input  logic          sr_req_i,
  input  logic          sr_exit_i,
  output logic          ref_req_o,
  output logic          ref_urgent_o,
  output logic          sr_cmd_o,
  output logic          cke_o,
  output logic          nop_only_o,
  output logic          sr_active_o,
  output logic [DW-1:0] debt_o
);
  logic run, enter, tick, zero, full;

  rfsh_sr_fsm #(.EXIT_WAIT(EXIT_WAIT)) u_fsm (
    .clk_i, .rst_ni,
    .sr_req_i, .sr_exit_i,
    .debt_zero_i (zero),
    .bank_idle_i,
    .run_o       (run),
    .enter_o     (enter),
    .cke_o,
    .nop_only_o,
    .sr_active_o
  );

  rfsh_tick #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk_i, .rst_ni,
    .run_i  (run && !enter),
    .tick_o (tick)
  );

  rfsh_debt #(.MAX_DEBT(MAX_DEBT), .DW(DW)) u_debt (
    .clk_i, .rst_ni,
    .tick_i (tick),
    .gnt_i  (ref_gnt_i && run),
    .debt_o,
    .zero_o (zero),
    .full_o (full)
  );

  assign ref_req_o    = run && !zero;
  assign ref_urgent_o = run && full;
  assign sr_cmd_o     = enter;
endmodule

// File: rtl/rfsh_sched_chk.sv
module rfsh_sched_chk #(
  parameter int MAX_DEBT = 8,
  parameter int DW       = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bank_idle_i,
  input logic          ref_gnt_i,
  input logic          ref_req_o,
  input logic          ref_urgent_o,
  input logic          sr_cmd_o,
  input logic          cke_o,
  input logic          nop_only_o,
  input logic          sr_active_o,
  input logic [DW-1:0] debt_o
);
  a_r5_debt_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    debt_o <= DW'(MAX_DEBT));

  a_r5_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (debt_o == DW'(MAX_DEBT) && !ref_gnt_i && !sr_active_o) |=> debt_o == DW'(MAX_DEBT));

  a_r6_unit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (debt_o == $past(debt_o)) || (debt_o == $past(debt_o) + 1'b1) || (debt_o + 1'b1 == $past(debt_o)));

  a_r4_urgent_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_urgent_o |-> ref_req_o);

  a_r7_entry_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_cmd_o |-> (debt_o == '0 && bank_idle_i && !cke_o));

  a_r7_enter_self: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_cmd_o |=> sr_active_o);

  a_r8_quiet_in_self: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_active_o |-> (!ref_req_o && !cke_o && nop_only_o && debt_o == '0));

  a_r9_exit_nop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sr_active_o) |-> (cke_o && nop_only_o));
endmodule

bind rfsh_sched rfsh_sched_chk #(.MAX_DEBT(MAX_DEBT), .DW(DW)) u_chk (
  .clk_i, .rst_ni, .bank_idle_i, .ref_gnt_i, .ref_req_o, .ref_urgent_o,
  .sr_cmd_o, .cke_o, .nop_only_o, .sr_active_o, .debt_o
);

// File: tb/sim_rfsh_sched.sv
module sim_rfsh_sched;
  localparam int TICK = 16;
  localparam int MAXD = 8;
  localparam int EXW  = 12;
  localparam int DW   = $clog2(MAXD + 1);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic bank_idle_i = 1'b0, ref_gnt_i = 1'b0, sr_req_i = 1'b0, sr_exit_i = 1'b0;
  logic ref_req_o, ref_urgent_o, sr_cmd_o, cke_o, nop_only_o, sr_active_o;
  logic [DW-1:0] debt_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rfsh_sched #(.TICK_CYCLES(TICK), .MAX_DEBT(MAXD), .EXIT_WAIT(EXW)) u0 (
    .clk_i(clk), .rst_ni, .bank_idle_i, .ref_gnt_i, .sr_req_i, .sr_exit_i,
    .ref_req_o, .ref_urgent_o, .sr_cmd_o, .cke_o, .nop_only_o, .sr_active_o, .debt_o
  );

  // {cycles held, grant level, expected debt}; req/urgent follow from debt
  typedef struct packed { logic [7:0] cyc; logic gnt; logic [3:0] debt; } vec_t;
  localparam int NV = 11;
  localparam vec_t VT [NV] = '{
    '{8'd15, 1'b0, 4'd0},  // R2 no tick yet
    '{8'd1,  1'b0, 4'd1},  // R2 first tick
    '{8'd96, 1'b0, 4'd7},
    '{8'd16, 1'b0, 4'd8},  // R4 urgent
    '{8'd32, 1'b0, 4'd8},  // R5 saturate
    '{8'd3,  1'b1, 4'd5},  // R6 grants pay off
    '{8'd5,  1'b1, 4'd0},
    '{8'd8,  1'b1, 4'd1},  // R6 grant at zero ignored, tick lands
    '{8'd15, 1'b0, 4'd1},
    '{8'd1,  1'b1, 4'd1},  // R6 tick+grant same cycle
    '{8'd1,  1'b1, 4'd0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 debt", debt_o, 0);
    chk("R1 req", ref_req_o, 0);
    chk("R1 urg", ref_urgent_o, 0);
    chk("R1 cke", cke_o, 1);
    chk("R1 nop", nop_only_o, 0);
    chk("R1 sr_active", sr_active_o, 0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      ref_gnt_i = VT[i].gnt;
      repeat (int'(VT[i].cyc)) @(negedge clk);
      chk($sformatf("R2/R6 vec%0d debt", i), debt_o, VT[i].debt);
      chk($sformatf("R3 vec%0d req", i), ref_req_o, VT[i].debt != 0);
      chk($sformatf("R4/R5 vec%0d urg", i), ref_urgent_o, VT[i].debt == MAXD);
    end
    ref_gnt_i = 1'b0;

    // R7 busy bank blocks entry
    sr_req_i = 1'b1; bank_idle_i = 1'b0;
    #1;
    chk("R7 busy no cmd", sr_cmd_o, 0);
    chk("R7 busy cke", cke_o, 1);
    @(negedge clk);
    chk("R7 busy stays run", sr_active_o, 0);
    bank_idle_i = 1'b1;
    #1;
    chk("R7 cmd", sr_cmd_o, 1);
    chk("R7 cke low same cycle", cke_o, 0);
    @(negedge clk);
    sr_req_i = 1'b0;
    chk("R8 active", sr_active_o, 1);
    repeat (40) @(negedge clk);
    chk("R8 cke", cke_o, 0);
    chk("R8 nop", nop_only_o, 1);
    chk("R8 req", ref_req_o, 0);
    chk("R8 debt", debt_o, 0);

    // R9 exit
    sr_exit_i = 1'b1;
    @(negedge clk);
    sr_exit_i = 1'b0;
    chk("R9 cke", cke_o, 1);
    chk("R9 nop", nop_only_o, 1);
    chk("R9 left self", sr_active_o, 0);
    repeat (EXW - 1) @(negedge clk);
    chk("R9 nop window end", nop_only_o, 1);
    @(negedge clk);
    chk("R9 nop released", nop_only_o, 0);
    repeat (TICK - 1) @(negedge clk);
    chk("R9 fresh interval", debt_o, 0);
    @(negedge clk);
    chk("R9 first tick", debt_o, 1);

    // R7 owed debt blocks entry
    sr_req_i = 1'b1;
    #1;
    chk("R7 debt no cmd", sr_cmd_o, 0);
    chk("R7 debt cke", cke_o, 1);
    @(negedge clk);
    chk("R7 debt stays run", sr_active_o, 0);
    sr_req_i = 1'b0;

    // R1 reset mid-run
    rst_ni = 1'b0;
    #1;
    chk("R1 rerst debt", debt_o, 0);
    chk("R1 rerst req", ref_req_o, 0);
    chk("R1 rerst cke", cke_o, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule